// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides, at each instruction boundary of a 32-bit graphics processor core, whether the core must enter an interrupt service routine, and which one. It keeps a pending register and an enable register for four maskable sources. Each pending bit is set by a one-cycle pulse from its source and cleared by a software write. The block also keeps a 16-bit host control word. That word carries a non-maskable request flag raised by the host, a flag that suppresses the context push for that request, and a halt flag.

When an interrupt is taken, the block pulses `trapTake`. At the same time it tells the core whether the PC and status must be pushed, which vector address to fetch, and which status value to load. It then raises `stall` for the fixed service time. The core performs the push and the memory read itself. It returns the fetched vector word on `vecData`, and the block hands it back on `newPc` aligned to a 16-bit instruction boundary.

Top module: `ivc_top`

## Requirements
- R1: After reset the pending and enable registers and the host control word are zero, and `trapTake`, `pushCtx`, `stall` and `halted` are low.
- R2: A pulse on `srcPulse[i]` sets pending bit i, with the bit mapping 0 = host, 1 = display, 2 = external 1, 3 = external 2. The bit is visible on `pendOut` one cycle later.
- R3: A pending write clears every pending bit whose data bit is 0 and keeps every bit whose data bit is 1. Writing the display bit (bit 1) as 0 therefore clears the display request.
- R4: When a set pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: A maskable interrupt is taken only on a cycle with `boundary` high, `statusIe` high and a nonzero AND of pending and enable. `trapTake` and `pushCtx` go high in the following cycle.
- R6: Among the requesting sources, the lowest bit index wins. The vector addresses are: host 0xFFFFFEC0, display 0xFFFFFEA0, external 1 0xFFFFFFC0, external 2 0xFFFFFFA0.
- R7: Host control bit 8 requests a non-maskable interrupt. It wins over all maskable requests, ignores `statusIe` and the enables, uses vector 0xFFFFFEE0, and is cleared when serviced.
- R8: For a non-maskable interrupt, `pushCtx` is high only when host control bit 9 is 0.
- R9: Every taken interrupt presents `newStatus` = 0x00000010. `newPc` always equals `vecData` with its low 4 bits forced to 0.
- R10: After each take, `stall` stays high for exactly 16 cycles, and boundaries that arrive while `stall` is high are ignored.
- R11: While host control bit 15 is set, `halted` is high and no interrupt of any kind is taken.
- R12: If a host control write and a non-maskable service fall in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe from the core |
| srcPulse | input | 4 | Set pulses, one per maskable source |
| pendWrEn | input | 1 | Software write strobe for the pending register |
| pendWrData | input | 4 | Pending write data (0 clears, 1 keeps) |
| enWrEn | input | 1 | Software write strobe for the enable register |
| enWrData | input | 4 | Enable register data |
| hostWrEn | input | 1 | Host control write strobe |
| hostWrData | input | 16 | Host control write data |
| statusIe | input | 1 | Interrupt-enable bit of the core status |
| vecData | input | 32 | Vector word fetched by the core |
| trapTake | output | 1 | One-cycle pulse: an interrupt is taken |
| pushCtx | output | 1 | PC and status must be pushed (valid with trapTake) |
| vecAddr | output | 32 | Address of the vector to fetch |
| newStatus | output | 32 | Status value to load on the take |
| newPc | output | 32 | Aligned PC derived from vecData |
| stall | output | 1 | Service stall in progress |
| halted | output | 1 | Core halted by host control bit 15 |
| pendOut | output | 4 | Current pending register |

## Verification
Arbitration is driven from a table that pairs pending patterns with enable masks and interrupt-enable settings. Single requests check each vector address on its own. Stacked requests show that the lowest index wins. Masked and globally disabled cases show that a pending bit alone never causes a take. Directed cases cover the non-maskable path with the push suppressed and with it allowed, and show that the flag is consumed because the following boundary falls through to the maskable winner. They also check the halt blocking both kinds of request, a boundary ignored in the middle of the stall, and the set-versus-clear collision on the display bit.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int SRC_N      = 4;
  localparam int ADDR_W     = 32;
  localparam int CTL_W      = 16;
  localparam int NMI_BIT    = 8;
  localparam int NOPUSH_BIT = 9;
  localparam int HALT_BIT   = 15;
  localparam logic [ADDR_W-1:0] NMI_VEC     = 32'hFFFF_FEE0;
  localparam logic [ADDR_W-1:0] TRAP_STATUS = 32'h0000_0010;

  // vector address per maskable source, index order is priority order
  function automatic logic [ADDR_W-1:0] srcVector(input int idx);
    case (idx)
      0:       srcVector = 32'hFFFF_FEC0;
      1:       srcVector = 32'hFFFF_FEA0;
      2:       srcVector = 32'hFFFF_FFC0;
      default: srcVector = 32'hFFFF_FFA0;
    endcase
  endfunction

  typedef struct packed {
    logic             take;
    logic             nmi;
    logic             doPush;
    logic [SRC_N-1:0] grant;
  } ctrlStrobe_t;
endpackage

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
#(
  parameter int SVC_CYC = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic             statusIe,
  input  logic [SRC_N-1:0] pendQ,
  input  logic [SRC_N-1:0] enQ,
  input  logic             nmiFlag,
  input  logic             noPush,
  input  logic             haltFlag,
  output ctrlStrobe_t      strobe,
  output logic             stall
);
  localparam int CNT_W = $clog2(SVC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SVC_CYC);

  logic [CNT_W-1:0] stallCnt;
  logic [SRC_N-1:0] reqMask;
  logic [SRC_N-1:0] grantRaw;
  logic             open;
  logic             maskTake;

  assign reqMask = pendQ & enQ;

  // lowest index wins: scan from the top, later hits overwrite
  always_comb begin
    grantRaw = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (reqMask[i]) begin
        grantRaw    = '0;
        grantRaw[i] = 1'b1;
      end
    end
  end

  assign open     = boundary && (stallCnt == '0) && !haltFlag;
  assign maskTake = open && !nmiFlag && statusIe && (|reqMask);

  always_comb begin
    strobe.nmi    = open && nmiFlag;
    strobe.take   = strobe.nmi || maskTake;
    strobe.grant  = maskTake ? grantRaw : '0;
    strobe.doPush = strobe.nmi ? !noPush : maskTake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
    end else if (strobe.take) begin
      stallCnt <= CNT_LOAD;
    end else if (stallCnt != '0) begin
      stallCnt <= stallCnt - 1'b1;
    end
  end

  assign stall = (stallCnt != '0);
endmodule

// File: rtl/ivc_dp.sv
module ivc_dp
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcPulse,
  input  logic              pendWrEn,
  input  logic [SRC_N-1:0]  pendWrData,
  input  logic              enWrEn,
  input  logic [SRC_N-1:0]  enWrData,
  input  logic              hostWrEn,
  input  logic [CTL_W-1:0]  hostWrData,
  input  logic [ADDR_W-1:0] vecData,
  input  ctrlStrobe_t       strobe,
  output logic [SRC_N-1:0]  pendQ,
  output logic [SRC_N-1:0]  enQ,
  output logic              nmiFlag,
  output logic              noPush,
  output logic              haltFlag,
  output logic              trapTake,
  output logic              pushCtx,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [ADDR_W-1:0] newStatus,
  output logic [ADDR_W-1:0] newPc
);
  logic [CTL_W-1:0]  hostCtl;
  logic [SRC_N-1:0]  keepMask;
  logic [ADDR_W-1:0] selVec;

  assign keepMask = pendWrEn ? pendWrData : '1;

  // set pulses are OR-ed after the clear so a collision leaves the bit set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      enQ   <= '0;
    end else begin
      pendQ <= (pendQ & keepMask) | srcPulse;
      if (enWrEn) enQ <= enWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostCtl <= '0;
    end else if (hostWrEn) begin
      hostCtl <= hostWrData;
    end else if (strobe.nmi) begin
      hostCtl[NMI_BIT] <= 1'b0;
    end
  end

  assign nmiFlag  = hostCtl[NMI_BIT];
  assign noPush   = hostCtl[NOPUSH_BIT];
  assign haltFlag = hostCtl[HALT_BIT];

  always_comb begin
    selVec = '0;
    if (strobe.nmi) begin
      selVec = NMI_VEC;
    end else begin
      for (int i = 0; i < SRC_N; i++) begin
        if (strobe.grant[i]) selVec = srcVector(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapTake  <= 1'b0;
      pushCtx   <= 1'b0;
      vecAddr   <= '0;
      newStatus <= '0;
    end else begin
      trapTake <= strobe.take;
      pushCtx  <= strobe.take && strobe.doPush;
      if (strobe.take) begin
        vecAddr   <= selVec;
        newStatus <= TRAP_STATUS;
      end
    end
  end

  assign newPc = {vecData[ADDR_W-1:4], 4'b0000};
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int SVC_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              boundary,
  input  logic [SRC_N-1:0]  srcPulse,
  input  logic              pendWrEn,
  input  logic [SRC_N-1:0]  pendWrData,
  input  logic              enWrEn,
  input  logic [SRC_N-1:0]  enWrData,
  input  logic              hostWrEn,
  input  logic [CTL_W-1:0]  hostWrData,
  input  logic              statusIe,
  input  logic [ADDR_W-1:0] vecData,
  output logic              trapTake,
  output logic              pushCtx,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [ADDR_W-1:0] newStatus,
  output logic [ADDR_W-1:0] newPc,
  output logic              stall,
  output logic              halted,
  output logic [SRC_N-1:0]  pendOut
);
  ctrlStrobe_t      strobe;
  logic [SRC_N-1:0] pendQ;
  logic [SRC_N-1:0] enQ;
  logic             nmiFlag;
  logic             noPush;
  logic             haltFlag;

  ivc_ctrl #(.SVC_CYC(SVC_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .statusIe(statusIe),
    .pendQ(pendQ), .enQ(enQ), .nmiFlag(nmiFlag), .noPush(noPush),
    .haltFlag(haltFlag), .strobe(strobe), .stall(stall)
  );

  ivc_dp u_dp (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .pendWrEn(pendWrEn),
    .pendWrData(pendWrData), .enWrEn(enWrEn), .enWrData(enWrData),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .vecData(vecData),
    .strobe(strobe), .pendQ(pendQ), .enQ(enQ), .nmiFlag(nmiFlag),
    .noPush(noPush), .haltFlag(haltFlag), .trapTake(trapTake),
    .pushCtx(pushCtx), .vecAddr(vecAddr), .newStatus(newStatus), .newPc(newPc)
  );

  assign halted  = haltFlag;
  assign pendOut = pendQ;
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk
  import ivc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              boundary,
  input logic [SRC_N-1:0]  srcPulse,
  input logic              trapTake,
  input logic              pushCtx,
  input logic [ADDR_W-1:0] newStatus,
  input logic              stall,
  input logic              halted,
  input logic [SRC_N-1:0]  pendOut
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> (($past(srcPulse) & ~pendOut) == '0));

  // R5
  take_after_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && trapTake) |-> $past(boundary));

  // R8
  push_with_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushCtx |-> trapTake);

  // R9
  trap_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTake |-> (newStatus == TRAP_STATUS));

  // R10
  stall_on_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTake |-> stall);

  // R10
  no_take_in_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && trapTake) |-> !$past(stall));

  // R11
  halt_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && trapTake) |-> !$past(halted));
endmodule

bind ivc_top ivc_chk u_chk (
  .clk(clk), .rstN(rstN), .boundary(boundary), .srcPulse(srcPulse),
  .trapTake(trapTake), .pushCtx(pushCtx), .newStatus(newStatus),
  .stall(stall), .halted(halted), .pendOut(pendOut)
);

// File: tb/ivc_top_tb.sv
`timescale 1ns/1ps
module ivc_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        boundary = 1'b0;
  logic [3:0]  srcPulse = '0;
  logic        pendWrEn = 1'b0;
  logic [3:0]  pendWrData = '0;
  logic        enWrEn = 1'b0;
  logic [3:0]  enWrData = '0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic        statusIe = 1'b0;
  logic [31:0] vecData = '0;
  logic        trapTake, pushCtx, stall, halted;
  logic [31:0] vecAddr, newStatus, newPc;
  logic [3:0]  pendOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ivc_top u_dut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .srcPulse(srcPulse),
    .pendWrEn(pendWrEn), .pendWrData(pendWrData), .enWrEn(enWrEn),
    .enWrData(enWrData), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .statusIe(statusIe), .vecData(vecData), .trapTake(trapTake),
    .pushCtx(pushCtx), .vecAddr(vecAddr), .newStatus(newStatus),
    .newPc(newPc), .stall(stall), .halted(halted), .pendOut(pendOut)
  );

  // {enable, set pulses, ie, expect take, expected vector}
  localparam int NV = 12;
  localparam logic [41:0] VEC_TAB [NV] = '{
    {4'hF, 4'h1, 1'b1, 1'b1, 32'hFFFF_FEC0},
    {4'hF, 4'h2, 1'b1, 1'b1, 32'hFFFF_FEA0},
    {4'hF, 4'h4, 1'b1, 1'b1, 32'hFFFF_FFC0},
    {4'hF, 4'h8, 1'b1, 1'b1, 32'hFFFF_FFA0},
    {4'hF, 4'hF, 1'b1, 1'b1, 32'hFFFF_FEC0},
    {4'hF, 4'hE, 1'b1, 1'b1, 32'hFFFF_FEA0},
    {4'hF, 4'hC, 1'b1, 1'b1, 32'hFFFF_FFC0},
    {4'h8, 4'hF, 1'b1, 1'b1, 32'hFFFF_FFA0},
    {4'h0, 4'hF, 1'b1, 1'b0, 32'h0},
    {4'hF, 4'hF, 1'b0, 1'b0, 32'h0},
    {4'h6, 4'h9, 1'b1, 1'b0, 32'h0},
    {4'h6, 4'hB, 1'b1, 1'b1, 32'hFFFF_FEA0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic clearPend();
    pendWrEn = 1'b1; pendWrData = 4'h0; tick(); pendWrEn = 1'b0;
  endtask

  task automatic hostWrite(input logic [15:0] d);
    hostWrEn = 1'b1; hostWrData = d; tick(); hostWrEn = 1'b0;
  endtask

  task automatic pulseBoundary();
    boundary = 1'b1; tick(); boundary = 1'b0;
  endtask

  task automatic waitOut();
    repeat (17) tick();
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      finishRun();
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk(pendOut == 4'h0 && !halted, "R1 pend/halt", {27'd0, halted, pendOut}, 32'h0);
    chk(!trapTake && !pushCtx && !stall, "R1 outputs", {29'd0, trapTake, pushCtx, stall}, 32'h0);

    // R5 R6 table walk
    for (int e = 0; e < NV; e++) begin
      logic [41:0] v;
      v = VEC_TAB[e];
      clearPend();
      enWrEn = 1'b1; enWrData = v[41:38]; srcPulse = v[37:34]; tick();
      enWrEn = 1'b0; srcPulse = '0;
      statusIe = v[33];
      pulseBoundary();
      chk(trapTake == v[32], "R5 take", {31'd0, trapTake}, {31'd0, v[32]});
      if (v[32]) begin
        chk(vecAddr == v[31:0], "R6 vector", vecAddr, v[31:0]);
        chk(pushCtx, "R5 push", {31'd0, pushCtx}, 32'd1);
      end
      waitOut();
    end
    statusIe = 1'b0;

    // R2 set pulses
    clearPend();
    srcPulse = 4'h5; tick(); srcPulse = '0;
    chk(pendOut == 4'h5, "R2 set", {28'd0, pendOut}, 32'h5);
    // R3 write zero clears display, ones keep
    srcPulse = 4'h2; tick(); srcPulse = '0;
    pendWrEn = 1'b1; pendWrData = 4'hD; tick(); pendWrEn = 1'b0;
    chk(pendOut == 4'h5, "R3 clear display", {28'd0, pendOut}, 32'h5);
    // R4 set beats clear
    pendWrEn = 1'b1; pendWrData = 4'h0; srcPulse = 4'h2; tick();
    pendWrEn = 1'b0; srcPulse = '0;
    chk(pendOut == 4'h2, "R4 set wins", {28'd0, pendOut}, 32'h2);

    // R7 NMI beats maskable, ignores ie; R9 status and aligned pc
    enWrEn = 1'b1; enWrData = 4'hF; srcPulse = 4'h1; tick(); enWrEn = 1'b0; srcPulse = '0;
    statusIe = 1'b0;
    vecData = 32'h1234_567B;
    hostWrite(16'h0100);
    pulseBoundary();
    chk(trapTake && vecAddr == 32'hFFFF_FEE0, "R7 nmi vector", vecAddr, 32'hFFFF_FEE0);
    chk(pushCtx, "R8 push allowed", {31'd0, pushCtx}, 32'd1);
    chk(newStatus == 32'h10, "R9 status", newStatus, 32'h10);
    chk(newPc == 32'h1234_5670, "R9 newPc", newPc, 32'h1234_5670);
    // R10 stall length and ignored boundary
    begin
      int n;
      n = 0;
      statusIe = 1'b1;
      while (stall && n < 40) begin
        n++;
        if (n == 4) boundary = 1'b1;
        tick();
        boundary = 1'b0;
        if (n == 4) chk(!trapTake, "R10 ignored boundary", {31'd0, trapTake}, 32'd0);
      end
      chk(n == 16, "R10 stall cycles", n, 32'd16);
    end
    // R7 flag consumed: next boundary takes maskable host source
    pulseBoundary();
    chk(trapTake && vecAddr == 32'hFFFF_FEC0, "R7 nmi cleared", vecAddr, 32'hFFFF_FEC0);
    waitOut();

    // R8 push suppressed
    hostWrite(16'h0300);
    pulseBoundary();
    chk(trapTake && !pushCtx, "R8 no push", {30'd0, trapTake, pushCtx}, 32'h2);
    waitOut();

    // R11 halt blocks maskable and NMI
    hostWrite(16'h8100);
    chk(halted, "R11 halted", {31'd0, halted}, 32'd1);
    pulseBoundary();
    chk(!trapTake, "R11 blocked", {31'd0, trapTake}, 32'd0);
    tick();

    // R12 host write wins over NMI service in same cycle
    hostWrite(16'h0100);
    hostWrEn = 1'b1; hostWrData = 16'h8100; boundary = 1'b1; tick();
    hostWrEn = 1'b0; boundary = 1'b0;
    chk(trapTake && halted, "R12 write kept", {30'd0, trapTake, halted}, 32'h3);
    waitOut();
    hostWrite(16'h0000);
    statusIe = 1'b0;
    pulseBoundary();
    chk(!trapTake, "R12 nmi flag written off", {31'd0, trapTake}, 32'd0);

    done = 1'b1;
    finishRun();
  end
endmodule